// File: doc/BRIEF.md
# Flag-Accurate Shift and Rotate Unit

This block is the shift and rotate execution unit of a 64-bit integer datapath. It takes a destination operand, a raw count, an operand-size code, an operation code and the incoming arithmetic flags. It returns the value to write back to the destination register, along with new carry, overflow, zero, sign and parity flags. Each flag has its own write enable, so the flag file can keep the bits the operation leaves alone.

The unit is purely combinational, so every output follows its inputs within the same cycle. It first masks the count according to the operand size. It then computes the operation on a lane of the selected width. Last, it merges the lane result into the 64-bit write-back value: a 32-bit result is zero-extended, and 8-bit and 16-bit results keep the destination's upper bits. A masked count of zero still produces a write-back value under the same merge rules, but it leaves every flag untouched.

Operation codes on `opSel` are: 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 left shift, 5 logical right shift, 6 arithmetic left shift (identical to code 4), 7 arithmetic right shift. Size codes on `sizeSel` are: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.

Top module: `shrot_unit`

## Requirements
- R1: The count used is `countIn` ANDed with 0x3F when `sizeSel` is 3 (64 bits), and ANDed with 0x1F for size codes 0, 1 and 2.
- R2: Left shifts (op 4 and 6) fill with zeros from the least-significant end. CF becomes the last bit moved out past the operand's most-significant bit, and is 0 when the masked count exceeds the width.
- R3: Logical right shift (op 5) fills vacated positions with zeros. CF becomes the last bit moved out past bit 0.
- R4: Arithmetic right shift (op 7) replicates the operand's sign bit into vacated positions. CF becomes the last bit moved out past bit 0.
- R5: Plain rotates (op 0 left, op 1 right) rotate by the masked count modulo the operand width N. After a left rotate CF equals result bit 0; after a right rotate CF equals result bit N-1.
- R6: Rotates through carry (op 2 left, op 3 right) rotate the (N+1)-bit value {CF, operand} by the masked count modulo N+1. CF takes the new top bit of that value.
- R7: When the masked count is zero, all five flag write enables are low and every flag output equals its incoming value. The write-back value still follows R8 and R9.
- R8: With size code 2, bits 63:32 of `resultOut` are zero for every operation and count, including a masked count of zero.
- R9: With size codes 0 and 1, `resultOut` bits above the operand width equal the same bits of `dstIn`.
- R10: With a masked count of 1, OF is written as follows:
  - left shift: result MSB XOR new CF
  - logical right shift: the operand's original MSB
  - arithmetic right shift: 0
  - left rotates: result MSB XOR new CF
  - right rotates: XOR of the result's two top bits
- R11: With a masked count greater than 1, OF is written with the value 0 and `ofWe` is high.
- R12: For a nonzero masked count, shifts write ZF (sized result is zero), SF (result MSB) and PF (1 when the low result byte has an even number of ones). Rotates hold ZF, SF and PF write enables low and pass the incoming values through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dstIn | input | 64 | Destination operand |
| countIn | input | 8 | Raw shift or rotate count |
| sizeSel | input | 2 | Operand size code (0:8, 1:16, 2:32, 3:64 bits) |
| opSel | input | 3 | Operation code (see above) |
| cfIn | input | 1 | Incoming carry flag |
| ofIn | input | 1 | Incoming overflow flag |
| zfIn | input | 1 | Incoming zero flag |
| sfIn | input | 1 | Incoming sign flag |
| pfIn | input | 1 | Incoming parity flag |
| resultOut | output | 64 | Value to write back to the destination |
| cfOut | output | 1 | Carry flag after the operation |
| ofOut | output | 1 | Overflow flag after the operation |
| zfOut | output | 1 | Zero flag after the operation |
| sfOut | output | 1 | Sign flag after the operation |
| pfOut | output | 1 | Parity flag after the operation |
| cfWe | output | 1 | Carry flag write enable |
| ofWe | output | 1 | Overflow flag write enable |
| zfWe | output | 1 | Zero flag write enable |
| sfWe | output | 1 | Sign flag write enable |
| pfWe | output | 1 | Parity flag write enable |

## Verification
There are no register stages between the ports. The write-back value, all five flags and all five write enables are therefore due in the same cycle the operands are applied. The bench changes inputs on the falling clock edge and samples every output one nanosecond later, well before the next rising edge, so each sample reflects only the current stimulus. Zero-count and rotate cases drive incoming flags that differ from what a write would produce, so a wrongly asserted enable or a changed flag value is visible at the ports in that same cycle.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  localparam int DATA_W   = 64;
  localparam int CNT_IN_W = 8;
  localparam int CNT_W    = $clog2(DATA_W);
  localparam int NUM_SIZES = 4;
  localparam int SIZE_W   = $clog2(NUM_SIZES);

  typedef enum logic [SIZE_W-1:0] {
    SZ8  = 2'd0,
    SZ16 = 2'd1,
    SZ32 = 2'd2,
    SZ64 = 2'd3
  } size_e;

  typedef enum logic [2:0] {
    OP_ROL = 3'd0,
    OP_ROR = 3'd1,
    OP_RCL = 3'd2,
    OP_RCR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAL = 3'd6,
    OP_SAR = 3'd7
  } op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              doShift;
    logic              doLeft;
    logic              doArith;
    logic              viaCarry;
    logic              countZero;
    logic              countOne;
    logic [SIZE_W-1:0] sizeCode;
    logic [CNT_W-1:0]  maskedCount;
  } ctrl_t;

endpackage

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
(
  input  logic [CNT_IN_W-1:0] countIn,
  input  logic [SIZE_W-1:0]   sizeSel,
  input  logic [2:0]          opSel,
  output ctrl_t               ctrl
);

  localparam logic [CNT_W-1:0] MASK_WIDE   = '1;
  localparam logic [CNT_W-1:0] MASK_NARROW = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] countMask;
  logic [CNT_W-1:0] maskedCnt;

  always_comb begin
    countMask = (size_e'(sizeSel) == SZ64) ? MASK_WIDE : MASK_NARROW;
    maskedCnt = countIn[CNT_W-1:0] & countMask;
  end

  always_comb begin
    ctrl.doShift     = opSel[2];
    ctrl.doLeft      = ~opSel[0];
    ctrl.doArith     = (op_e'(opSel) == OP_SAR);
    ctrl.viaCarry    = (op_e'(opSel) == OP_RCL) || (op_e'(opSel) == OP_RCR);
    ctrl.countZero   = (maskedCnt == '0);
    ctrl.countOne    = (maskedCnt == CNT_W'(1));
    ctrl.sizeCode    = sizeSel;
    ctrl.maskedCount = maskedCnt;
  end

  // R1: narrow operand sizes never see a count of 32 or more
  always_comb begin
    if (size_e'(sizeSel) != SZ64)
      a_r1_count_mask: assert (ctrl.maskedCount[CNT_W-1] == 1'b0)
        else $error("masked count exceeds 31 for narrow size");
  end

endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W = 8
)(
  input  logic [W-1:0] a,
  input  logic         cfIn,
  input  ctrl_t        ctrl,
  output logic [W-1:0] val,
  output logic         cfNew,
  output logic         ofOne
);

  logic [W:0]       shlWide;
  logic [W:0]       shrWide;
  logic [W:0]       rcVec;
  logic [W:0]       rclVec;
  logic [W:0]       rcrVec;
  logic [W-1:0]     rolVal;
  logic [W-1:0]     rorVal;
  logic [CNT_W-1:0] rotAmt;
  logic [CNT_W-1:0] rcAmt;

  assign rotAmt = CNT_W'(ctrl.maskedCount % W);
  assign rcAmt  = CNT_W'(ctrl.maskedCount % (W + 1));
  assign rcVec  = {cfIn, a};

  always_comb begin
    shlWide = {1'b0, a} << ctrl.maskedCount;
    if (ctrl.doArith)
      shrWide = $signed({a, 1'b0}) >>> ctrl.maskedCount;
    else
      shrWide = {a, 1'b0} >> ctrl.maskedCount;
    rolVal = (a << rotAmt) | (a >> (W - int'(rotAmt)));
    rorVal = (a >> rotAmt) | (a << (W - int'(rotAmt)));
    rclVec = (rcVec << rcAmt) | (rcVec >> (W + 1 - int'(rcAmt)));
    rcrVec = (rcVec >> rcAmt) | (rcVec << (W + 1 - int'(rcAmt)));
  end

  always_comb begin
    if (ctrl.doShift) begin
      if (ctrl.doLeft) begin
        val   = shlWide[W-1:0];
        cfNew = shlWide[W];
        ofOne = shlWide[W-1] ^ shlWide[W];
      end else begin
        val   = shrWide[W:1];
        cfNew = shrWide[0];
        ofOne = ctrl.doArith ? 1'b0 : a[W-1];
      end
    end else if (ctrl.viaCarry) begin
      if (ctrl.doLeft) begin
        val   = rclVec[W-1:0];
        cfNew = rclVec[W];
        ofOne = rclVec[W-1] ^ rclVec[W];
      end else begin
        val   = rcrVec[W-1:0];
        cfNew = rcrVec[W];
        ofOne = rcrVec[W-1] ^ rcrVec[W-2];
      end
    end else begin
      if (ctrl.doLeft) begin
        val   = rolVal;
        cfNew = rolVal[0];
        ofOne = rolVal[W-1] ^ rolVal[0];
      end else begin
        val   = rorVal;
        cfNew = rorVal[W-1];
        ofOne = rorVal[W-1] ^ rorVal[W-2];
      end
    end
  end

  // R7: a zero count leaves the lane value equal to its operand
  always_comb begin
    if (ctrl.countZero)
      a_r7_lane_identity: assert (val == a)
        else $error("lane altered operand on zero count");
  end

endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
(
  input  logic [DATA_W-1:0] dstIn,
  input  logic              cfIn,
  input  logic              ofIn,
  input  logic              zfIn,
  input  logic              sfIn,
  input  logic              pfIn,
  input  ctrl_t             ctrl,
  output logic [DATA_W-1:0] resultOut,
  output logic              cfOut,
  output logic              ofOut,
  output logic              zfOut,
  output logic              sfOut,
  output logic              pfOut,
  output logic              cfWe,
  output logic              ofWe,
  output logic              zfWe,
  output logic              sfWe,
  output logic              pfWe
);

  logic [DATA_W-1:0] laneRes [NUM_SIZES];
  logic              laneCf  [NUM_SIZES];
  logic              laneOf  [NUM_SIZES];
  logic              laneZ   [NUM_SIZES];
  logic              laneS   [NUM_SIZES];
  logic              laneP   [NUM_SIZES];

  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_lane
    localparam int LW = 8 << i;
    logic [LW-1:0] laneVal;
    logic          laneCfNew;
    logic          laneOfOne;

    shrot_lane #(.W(LW)) u_lane (
      .a     (dstIn[LW-1:0]),
      .cfIn  (cfIn),
      .ctrl  (ctrl),
      .val   (laneVal),
      .cfNew (laneCfNew),
      .ofOne (laneOfOne)
    );

    if (LW == DATA_W) begin : g_full
      assign laneRes[i] = laneVal;
    end else if (LW == 32) begin : g_zext
      assign laneRes[i] = {{(DATA_W-LW){1'b0}}, laneVal};
    end else begin : g_keep
      assign laneRes[i] = {dstIn[DATA_W-1:LW], laneVal};
    end

    assign laneCf[i] = laneCfNew;
    assign laneOf[i] = laneOfOne;
    assign laneZ[i]  = (laneVal == '0);
    assign laneS[i]  = laneVal[LW-1];
    assign laneP[i]  = ~^laneVal[7:0];
  end

  logic writeCo;
  logic writeZsp;

  always_comb begin
    writeCo  = ~ctrl.countZero;
    writeZsp = ~ctrl.countZero & ctrl.doShift;

    resultOut = laneRes[ctrl.sizeCode];

    cfWe = writeCo;
    ofWe = writeCo;
    zfWe = writeZsp;
    sfWe = writeZsp;
    pfWe = writeZsp;

    cfOut = writeCo  ? laneCf[ctrl.sizeCode] : cfIn;
    ofOut = writeCo  ? (ctrl.countOne & laneOf[ctrl.sizeCode]) : ofIn;
    zfOut = writeZsp ? laneZ[ctrl.sizeCode] : zfIn;
    sfOut = writeZsp ? laneS[ctrl.sizeCode] : sfIn;
    pfOut = writeZsp ? laneP[ctrl.sizeCode] : pfIn;
  end

  // Checks on the merged write-back and the flag outputs
  always_comb begin
    if (size_e'(ctrl.sizeCode) == SZ32)
      a_r8_zero_upper: assert (resultOut[DATA_W-1:32] == '0)
        else $error("32-bit result not zero-extended");
    if (size_e'(ctrl.sizeCode) == SZ8)
      a_r9_keep_upper8: assert (resultOut[DATA_W-1:8] == dstIn[DATA_W-1:8])
        else $error("8-bit result disturbed upper bits");
    if (size_e'(ctrl.sizeCode) == SZ16)
      a_r9_keep_upper16: assert (resultOut[DATA_W-1:16] == dstIn[DATA_W-1:16])
        else $error("16-bit result disturbed upper bits");
    if (ctrl.countZero)
      a_r7_flags_held: assert (!cfWe && !ofWe && !zfWe && !sfWe && !pfWe &&
                               cfOut == cfIn && ofOut == ofIn && zfOut == zfIn &&
                               sfOut == sfIn && pfOut == pfIn)
        else $error("flags touched on zero count");
    if (!ctrl.doShift)
      a_r12_rotate_zsp: assert (!zfWe && !sfWe && !pfWe)
        else $error("rotate wrote ZF/SF/PF");
    if (!ctrl.countZero && !ctrl.countOne)
      a_r11_of_cleared: assert (ofWe && !ofOut)
        else $error("OF not cleared for count above 1");
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
(
  input  logic [63:0] dstIn,
  input  logic [7:0]  countIn,
  input  logic [1:0]  sizeSel,
  input  logic [2:0]  opSel,
  input  logic        cfIn,
  input  logic        ofIn,
  input  logic        zfIn,
  input  logic        sfIn,
  input  logic        pfIn,
  output logic [63:0] resultOut,
  output logic        cfOut,
  output logic        ofOut,
  output logic        zfOut,
  output logic        sfOut,
  output logic        pfOut,
  output logic        cfWe,
  output logic        ofWe,
  output logic        zfWe,
  output logic        sfWe,
  output logic        pfWe
);

  ctrl_t ctrl;

  shrot_ctrl u_ctrl (
    .countIn (countIn),
    .sizeSel (sizeSel),
    .opSel   (opSel),
    .ctrl    (ctrl)
  );

  shrot_datapath u_dp (
    .dstIn     (dstIn),
    .cfIn      (cfIn),
    .ofIn      (ofIn),
    .zfIn      (zfIn),
    .sfIn      (sfIn),
    .pfIn      (pfIn),
    .ctrl      (ctrl),
    .resultOut (resultOut),
    .cfOut     (cfOut),
    .ofOut     (ofOut),
    .zfOut     (zfOut),
    .sfOut     (sfOut),
    .pfOut     (pfOut),
    .cfWe      (cfWe),
    .ofWe      (ofWe),
    .zfWe      (zfWe),
    .sfWe      (sfWe),
    .pfWe      (pfWe)
  );

endmodule

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] dstIn = '0;
  logic [7:0]  countIn = '0;
  logic [1:0]  sizeSel = '0;
  logic [2:0]  opSel = '0;
  logic        cfIn = 1'b0, ofIn = 1'b0, zfIn = 1'b0, sfIn = 1'b0, pfIn = 1'b0;
  logic [63:0] resultOut;
  logic        cfOut, ofOut, zfOut, sfOut, pfOut;
  logic        cfWe, ofWe, zfWe, sfWe, pfWe;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shrot_unit u_shrot_unit (
    .dstIn(dstIn), .countIn(countIn), .sizeSel(sizeSel), .opSel(opSel),
    .cfIn(cfIn), .ofIn(ofIn), .zfIn(zfIn), .sfIn(sfIn), .pfIn(pfIn),
    .resultOut(resultOut), .cfOut(cfOut), .ofOut(ofOut), .zfOut(zfOut),
    .sfOut(sfOut), .pfOut(pfOut), .cfWe(cfWe), .ofWe(ofWe), .zfWe(zfWe),
    .sfWe(sfWe), .pfWe(pfWe)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [7:0]  cnt;
    logic [63:0] dst;
    logic        cf;
    logic [63:0] res;
    logic        eCf;
    logic        eOf;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{8'd2,  3'd4, 2'd3, 8'd4,  64'h8000_0000_0000_0001, 1'b0, 64'h0000_0000_0000_0010, 1'b0, 1'b0}, // R2
    '{8'd10, 3'd4, 2'd3, 8'd1,  64'h4000_0000_0000_0000, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b1}, // R10
    '{8'd9,  3'd6, 2'd0, 8'd1,  64'h1234_5678_9ABC_DE81, 1'b0, 64'h1234_5678_9ABC_DE02, 1'b1, 1'b1}, // R9
    '{8'd3,  3'd5, 2'd2, 8'd4,  64'hFFFF_FFFF_8000_0018, 1'b0, 64'h0000_0000_0800_0001, 1'b1, 1'b0}, // R3
    '{8'd10, 3'd5, 2'd1, 8'd1,  64'hAAAA_AAAA_AAAA_8001, 1'b0, 64'hAAAA_AAAA_AAAA_4000, 1'b1, 1'b1}, // R10
    '{8'd4,  3'd7, 2'd3, 8'd8,  64'h8000_0000_0000_0100, 1'b0, 64'hFF80_0000_0000_0001, 1'b0, 1'b0}, // R4
    '{8'd4,  3'd7, 2'd0, 8'd1,  64'h0000_0000_0000_0081, 1'b0, 64'h0000_0000_0000_00C0, 1'b1, 1'b0}, // R4
    '{8'd1,  3'd4, 2'd3, 8'h41, 64'h0000_0000_0000_0001, 1'b0, 64'h0000_0000_0000_0002, 1'b0, 1'b0}, // R1
    '{8'd1,  3'd4, 2'd2, 8'h21, 64'h0000_0001_8000_0001, 1'b0, 64'h0000_0000_0000_0002, 1'b1, 1'b1}, // R1
    '{8'd5,  3'd0, 2'd0, 8'd9,  64'h0000_0000_0000_0081, 1'b0, 64'h0000_0000_0000_0003, 1'b1, 1'b0}, // R5
    '{8'd5,  3'd1, 2'd3, 8'd4,  64'h0000_0000_0000_000F, 1'b0, 64'hF000_0000_0000_0000, 1'b1, 1'b0}, // R5
    '{8'd10, 3'd0, 2'd1, 8'd1,  64'h0000_0000_0000_8000, 1'b0, 64'h0000_0000_0000_0001, 1'b1, 1'b1}, // R10
    '{8'd6,  3'd2, 2'd0, 8'd1,  64'h0000_0000_0000_0080, 1'b0, 64'h0000_0000_0000_0000, 1'b1, 1'b1}, // R6
    '{8'd6,  3'd2, 2'd0, 8'd9,  64'h0000_0000_0000_005A, 1'b1, 64'h0000_0000_0000_005A, 1'b1, 1'b0}, // R6
    '{8'd6,  3'd3, 2'd0, 8'd1,  64'h0000_0000_0000_0001, 1'b1, 64'h0000_0000_0000_0080, 1'b1, 1'b1}, // R6
    '{8'd6,  3'd3, 2'd1, 8'd17, 64'h0000_0000_0000_1234, 1'b0, 64'h0000_0000_0000_1234, 1'b0, 1'b0}, // R6
    '{8'd8,  3'd2, 2'd2, 8'd2,  64'hFFFF_FFFF_8000_0000, 1'b1, 64'h0000_0000_0000_0003, 1'b0, 1'b0}, // R8
    '{8'd10, 3'd1, 2'd2, 8'd1,  64'h0000_0000_0000_0001, 1'b0, 64'h0000_0000_8000_0000, 1'b1, 1'b1}  // R10
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] op, logic [1:0] sz, logic [7:0] cnt, logic [63:0] dst,
                       logic [4:0] flagsIn);
    @(negedge clk);
    opSel = op; sizeSel = sz; countIn = cnt; dstIn = dst;
    {cfIn, ofIn, zfIn, sfIn, pfIn} = flagsIn;
    #1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // Idle state: all-zero inputs give zero result and no flag writes (R7)
    apply(3'd0, 2'd0, 8'd0, 64'd0, 5'b00000);
    chk("R7 idle result", resultOut, 64'd0);
    chk("R7 idle enables", {59'd0, cfWe, ofWe, zfWe, sfWe, pfWe}, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].op, VECS[i].sz, VECS[i].cnt, VECS[i].dst, {VECS[i].cf, 4'b0000});
      chk($sformatf("R%0d vec%0d result", VECS[i].req, i), resultOut, VECS[i].res);
      chk($sformatf("R%0d vec%0d cf", VECS[i].req, i), {63'd0, cfOut}, {63'd0, VECS[i].eCf});
      chk($sformatf("R%0d vec%0d of", VECS[i].req, i), {63'd0, ofOut}, {63'd0, VECS[i].eOf});
      chk($sformatf("R%0d vec%0d cf/of we", VECS[i].req, i), {62'd0, cfWe, ofWe}, 64'd3);
    end

    // R8 and R7: 32-bit left shift by zero still zero-extends, flags held
    apply(3'd4, 2'd2, 8'd0, 64'hFFFF_FFFF_0000_0001, 5'b11111);
    chk("R8 zero-count zext", resultOut, 64'h0000_0000_0000_0001);
    chk("R7 zero-count enables", {59'd0, cfWe, ofWe, zfWe, sfWe, pfWe}, 64'd0);
    chk("R7 zero-count flags", {59'd0, cfOut, ofOut, zfOut, sfOut, pfOut}, 64'h1F);

    // R1 and R8: count 0x20 masks to zero at 32 bits, rotate right
    apply(3'd1, 2'd2, 8'h20, 64'hDEAD_BEEF_1234_5678, 5'b10101);
    chk("R8 masked-zero rotate zext", resultOut, 64'h0000_0000_1234_5678);
    chk("R7 masked-zero flags", {59'd0, cfOut, ofOut, zfOut, sfOut, pfOut}, 64'h15);

    // R8: rotate through carry by zero at 32 bits
    apply(3'd2, 2'd2, 8'd0, 64'hCAFE_0000_0000_00FF, 5'b01010);
    chk("R8 rcl zero zext", resultOut, 64'h0000_0000_0000_00FF);
    chk("R7 rcl zero enables", {59'd0, cfWe, ofWe, zfWe, sfWe, pfWe}, 64'd0);

    // R1 and R9: 8-bit count 0x40 masks to zero, full value unchanged
    apply(3'd7, 2'd0, 8'h40, 64'hDEAD_BEEF_1234_5681, 5'b01010);
    chk("R9 masked-zero byte", resultOut, 64'hDEAD_BEEF_1234_5681);
    chk("R7 byte zero flags", {59'd0, cfOut, ofOut, zfOut, sfOut, pfOut}, 64'h0A);

    // R12: shift flags; 0x40<<1 = 0x80: ZF0 SF1 PF0
    apply(3'd4, 2'd0, 8'd1, 64'h0000_0000_0000_0040, 5'b00101);
    chk("R12 shl8 zsp", {61'd0, zfOut, sfOut, pfOut}, 64'b010);
    chk("R12 shl8 enables", {59'd0, cfWe, ofWe, zfWe, sfWe, pfWe}, 64'h1F);

    // R12 and R3: 1>>63 gives 0: ZF1 SF0 PF1, CF0
    apply(3'd5, 2'd3, 8'd63, 64'h0000_0000_0000_0001, 5'b10010);
    chk("R12 shr64 result", resultOut, 64'd0);
    chk("R12 shr64 zsp", {61'd0, zfOut, sfOut, pfOut}, 64'b101);
    chk("R3 shr64 cf", {63'd0, cfOut}, 64'd0);

    // R12: rotate keeps ZF/SF/PF as incoming
    apply(3'd0, 2'd3, 8'd3, 64'h0000_0000_0000_0000, 5'b00101);
    chk("R12 rotate zsp enables", {61'd0, zfWe, sfWe, pfWe}, 64'd0);
    chk("R12 rotate zsp pass", {61'd0, zfOut, sfOut, pfOut}, 64'b101);

    // R11: count 2 clears OF although incoming OF is set
    apply(3'd4, 2'd3, 8'd2, 64'h4000_0000_0000_0000, 5'b01000);
    chk("R11 of value", {62'd0, ofWe, ofOut}, 64'b10);

    // R2: left shift past width at 8 bits yields zero and CF 0
    apply(3'd6, 2'd0, 8'd12, 64'h0000_0000_0000_00FF, 5'b10000);
    chk("R2 shl over width", resultOut, 64'd0);
    chk("R2 shl over width cf", {63'd0, cfOut}, 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule